// File: doc/BRIEF.md
# I2C Serial EEPROM Target

This block is a bus target on a two-wire I2C bus that behaves like a small serial EEPROM. It samples the clock and data lines with the system clock and finds start and stop conditions. It answers only to a control byte whose upper nibble equals a fixed code and whose three select bits equal a set of strap inputs. The memory is an internal register array. Its size, page length and number of word-address bytes are parameters, defaulting to 128 bytes, 8-byte pages and one address byte. Memory size and page length must be powers of two, and the page length must be at least 2.

The target supports single-byte and page writes, current-address reads, random reads and sequential reads. One persistent address counter serves all reads. Written bytes collect in a page buffer and reach the memory only when the master sends a stop. Bytes written past the end of a page wrap to the start of the same page. The data line is driven only low, through `sdaOe`; the pad or the board supplies the open-drain path.

Top module: `i2c_eeprom_target`

## Requirements
- R1: The control byte is sent MSB first: code[3:0], select[2:0], then the R/W bit (1 = read). The target pulls SDA low in the acknowledge slot only when the code equals CTRL_CODE (default 4'b1010) and the select bits equal `strapSel`. On a mismatch it leaves SDA alone until the next start, and no memory location or counter changes.
- R2: A write consists of a write control byte, the word address and one data byte, followed by a stop. It stores that byte at the word address, and the target acknowledges every byte.
- R3: In a multi-byte write only the low log2(PAGE_BYTES) address bits advance, so a byte past the page end lands at the start of the same page.
- R4: A read control byte with no word address returns the byte at the address counter and then advances the counter. After reset the counter is 0 and every memory byte is 0x00.
- R5: A random read loads the counter from the word address and returns the byte there. It consists of a write control byte, the word address, a repeated start and a read control byte.
- R6: While the master acknowledges, the target returns successive bytes. The address wraps from MEM_BYTES-1 to 0.
- R7: After the master's not-acknowledge the target releases SDA and sends nothing more until the next start.
- R8: Write data reaches memory only at a stop. A repeated start discards buffered write data, so a write cut short by a repeated start leaves the memory unchanged.
- R9: `sdaOe` is low out of reset and changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Bus clock line as seen at the pad |
| sdaIn | input | 1 | Bus data line as seen at the pad |
| strapSel | input | 3 | Board-strapped select value the control byte must match |
| sdaOe | output | 1 | 1 = pull the data line low |

## Verification
The hardest case to reach from the ports is a discarded write. The master sends data bytes, then a repeated start with no stop, and a later read must show that nothing was committed. The bench builds that case directly: it sends the data byte, issues a repeated start, reads through the counter and stops. It then reads the location back with a random read. The page wrap and the counter rollover at the last address are reached the same way: writes set up chosen locations, and multi-byte reads run across the boundary.

// File: rtl/i2cEepromPkg.sv
package i2cEepromPkg;

  // Strobes from bus control to the storage datapath, one cycle wide.
  typedef struct packed {
    logic       addrByte;  // received byte is a word-address byte
    logic       dataByte;  // received byte is write data
    logic       rdLoad;    // fetch byte at counter, then advance counter
    logic       commit;    // stop seen: write buffered page into memory
    logic       discard;   // start seen: drop buffered write data
    logic [7:0] rxData;    // last byte shifted in from the bus
  } dpCmd_t;

endpackage

// File: rtl/i2c_eeprom_ctrl.sv
module i2c_eeprom_ctrl
  import i2cEepromPkg::*;
#(
  parameter int          ADDR_BYTES = 1,
  parameter logic [3:0]  CTRL_CODE  = 4'b1010
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic [2:0] strapSel,
  input  logic [7:0] txByte,
  output logic       sdaOe,
  output dpCmd_t     cmd
);

  localparam int ACW = $clog2(ADDR_BYTES + 1);

  typedef enum logic [2:0] {S_IDLE, S_RX, S_ACK, S_TX, S_MACK} state_t;
  typedef enum logic [1:0] {K_CTRL, K_ADDR, K_DATA} kind_t;

  state_t         state;
  kind_t          kind;
  logic [1:0]     sclSync, sdaSync;
  logic           sclQ, sdaQ;
  logic           scl, sda;
  logic           startEv, stopEv, sclRise, sclFall;
  logic [2:0]     bitCnt;
  logic [7:0]     shReg;
  logic           gotByte, goRead, mAck;
  logic [ACW-1:0] addrLeft;
  logic           ctrlHit;

  // Two-flop synchronisers plus one history stage for edge detection.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSync <= 2'b11;
      sdaSync <= 2'b11;
      sclQ    <= 1'b1;
      sdaQ    <= 1'b1;
    end else begin
      sclSync <= {sclSync[0], sclIn};
      sdaSync <= {sdaSync[0], sdaIn};
      sclQ    <= scl;
      sdaQ    <= sda;
    end
  end

  assign scl     = sclSync[1];
  assign sda     = sdaSync[1];
  assign startEv = scl & sclQ & sdaQ & ~sda;
  assign stopEv  = scl & sclQ & ~sdaQ & sda;
  assign sclRise = scl & ~sclQ;
  assign sclFall = ~scl & sclQ;
  assign ctrlHit = (shReg[7:4] == CTRL_CODE) && (shReg[3:1] == strapSel);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_IDLE;
      kind     <= K_CTRL;
      bitCnt   <= '0;
      shReg    <= '0;
      gotByte  <= 1'b0;
      goRead   <= 1'b0;
      mAck     <= 1'b0;
      addrLeft <= '0;
      cmd      <= '0;
    end else begin
      cmd        <= '0;
      cmd.rxData <= shReg;
      if (startEv) begin
        state       <= S_RX;
        kind        <= K_CTRL;
        bitCnt      <= '0;
        gotByte     <= 1'b0;
        cmd.discard <= 1'b1;
      end else if (stopEv) begin
        state      <= S_IDLE;
        cmd.commit <= 1'b1;
      end else begin
        case (state)
          S_RX: begin
            if (sclRise) begin
              shReg  <= {shReg[6:0], sda};
              bitCnt <= bitCnt + 1'b1;
              if (bitCnt == 3'd7) gotByte <= 1'b1;
            end else if (sclFall && gotByte) begin
              gotByte <= 1'b0;
              case (kind)
                K_CTRL: begin
                  if (ctrlHit) begin
                    state  <= S_ACK;
                    goRead <= shReg[0];
                    if (shReg[0]) begin
                      cmd.rdLoad <= 1'b1;
                    end else begin
                      kind     <= K_ADDR;
                      addrLeft <= ACW'(ADDR_BYTES);
                    end
                  end else begin
                    state <= S_IDLE;
                  end
                end
                K_ADDR: begin
                  cmd.addrByte <= 1'b1;
                  state        <= S_ACK;
                  goRead       <= 1'b0;
                  addrLeft     <= addrLeft - 1'b1;
                  if (addrLeft == ACW'(1)) kind <= K_DATA;
                end
                default: begin
                  cmd.dataByte <= 1'b1;
                  state        <= S_ACK;
                  goRead       <= 1'b0;
                end
              endcase
            end
          end
          S_ACK: begin
            if (sclFall) begin
              bitCnt <= '0;
              state  <= goRead ? S_TX : S_RX;
            end
          end
          S_TX: begin
            if (sclFall) begin
              bitCnt <= bitCnt + 1'b1;
              if (bitCnt == 3'd7) state <= S_MACK;
            end
          end
          S_MACK: begin
            if (sclRise) begin
              mAck <= ~sda;
            end else if (sclFall) begin
              if (mAck) begin
                state      <= S_TX;
                bitCnt     <= '0;
                cmd.rdLoad <= 1'b1;
              end else begin
                state <= S_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  // Pull low in our acknowledge slot, or for a 0 bit while sending data.
  assign sdaOe = (state == S_ACK) || ((state == S_TX) && !txByte[3'd7 - bitCnt]);

  AST_NO_ACK_ON_MISMATCH: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_RX && kind == K_CTRL && sclFall && gotByte && !ctrlHit && !startEv && !stopEv)
    |=> !sdaOe) else $error("control mismatch acknowledged"); // R1

  AST_COMMIT_AFTER_STOP: assert property (@(posedge clk) disable iff (!rstN)
    cmd.commit |-> $past(stopEv)) else $error("commit without stop"); // R8

  AST_SDA_HOLD_SCL_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (scl && sclQ) |-> ($stable(sdaOe) || $past(startEv || stopEv)))
    else $error("SDA drive moved while SCL high"); // R9

endmodule

// File: rtl/i2c_eeprom_store.sv
module i2c_eeprom_store
  import i2cEepromPkg::*;
#(
  parameter int MEM_BYTES  = 128,
  parameter int PAGE_BYTES = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  dpCmd_t     cmd,
  output logic [7:0] txByte
);

  localparam int AW   = $clog2(MEM_BYTES);
  localparam int PW   = $clog2(PAGE_BYTES);
  localparam int LAST = MEM_BYTES - 1;

  logic [7:0]            memArr  [MEM_BYTES];
  logic [7:0]            pageBuf [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] bufValid;
  logic [AW-1:0]         addrCnt;
  logic [AW+7:0]         addrShift;

  // Address bytes shift in high byte first; excess high bits fall off.
  assign addrShift = {addrCnt, cmd.rxData};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrCnt  <= '0;
      txByte   <= '0;
      bufValid <= '0;
      for (int i = 0; i < MEM_BYTES; i++)  memArr[i]  <= '0;
      for (int i = 0; i < PAGE_BYTES; i++) pageBuf[i] <= '0;
    end else begin
      if (cmd.discard) bufValid <= '0;
      if (cmd.addrByte) addrCnt <= addrShift[AW-1:0];
      if (cmd.dataByte) begin
        pageBuf[addrCnt[PW-1:0]]  <= cmd.rxData;
        bufValid[addrCnt[PW-1:0]] <= 1'b1;
        addrCnt <= {addrCnt[AW-1:PW], addrCnt[PW-1:0] + 1'b1};
      end
      if (cmd.rdLoad) begin
        txByte  <= memArr[addrCnt];
        addrCnt <= (addrCnt == AW'(LAST)) ? '0 : addrCnt + 1'b1;
      end
      if (cmd.commit) begin
        for (int i = 0; i < PAGE_BYTES; i++) begin
          if (bufValid[i]) memArr[{addrCnt[AW-1:PW], PW'(i)}] <= pageBuf[i];
        end
        bufValid <= '0;
      end
    end
  end

  AST_PAGE_STAYS: assert property (@(posedge clk) disable iff (!rstN)
    cmd.dataByte |=> addrCnt[AW-1:PW] == $past(addrCnt[AW-1:PW]))
    else $error("page write left its page"); // R3

  AST_READ_ROLLOVER: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.rdLoad && addrCnt == AW'(LAST)) |=> addrCnt == '0)
    else $error("read counter did not roll over"); // R6

endmodule

// File: rtl/i2c_eeprom_target.sv
module i2c_eeprom_target
  import i2cEepromPkg::*;
#(
  parameter int         MEM_BYTES  = 128,
  parameter int         PAGE_BYTES = 8,
  parameter int         ADDR_BYTES = 1,
  parameter logic [3:0] CTRL_CODE  = 4'b1010
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic [2:0] strapSel,
  output logic       sdaOe
);

  dpCmd_t     cmd;
  logic [7:0] txByte;

  i2c_eeprom_ctrl #(
    .ADDR_BYTES(ADDR_BYTES),
    .CTRL_CODE (CTRL_CODE)
  ) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .sclIn   (sclIn),
    .sdaIn   (sdaIn),
    .strapSel(strapSel),
    .txByte  (txByte),
    .sdaOe   (sdaOe),
    .cmd     (cmd)
  );

  i2c_eeprom_store #(
    .MEM_BYTES (MEM_BYTES),
    .PAGE_BYTES(PAGE_BYTES)
  ) uStore (
    .clk   (clk),
    .rstN  (rstN),
    .cmd   (cmd),
    .txByte(txByte)
  );

endmodule

// File: tb/i2c_eeprom_target_test.sv
module i2c_eeprom_target_test;

  localparam int         Q     = 10;
  localparam logic [2:0] STRAP = 3'b101;
  localparam logic [7:0] CW    = 8'hAA;  // 1010_101_0
  localparam logic [7:0] CR    = 8'hAB;  // 1010_101_1

  logic clk = 1'b0, rstN = 1'b0, sclDrv = 1'b1, sdaDrv = 1'b1;
  logic sdaOe, sdaBus;
  assign sdaBus = sdaDrv & ~sdaOe;

  always #5 clk = ~clk;

  i2c_eeprom_target uut (
    .clk(clk), .rstN(rstN), .sclIn(sclDrv), .sdaIn(sdaBus),
    .strapSel(STRAP), .sdaOe(sdaOe)
  );

  typedef struct {string req; logic [7:0] val;} exp_t;
  exp_t       expQ[$];
  logic [7:0] obsByte;
  event       obsEv;
  int         nCmp = 0, nBad = 0, r9Viol = 0, shCnt = 0;
  logic [7:0] shadow [128];
  logic [7:0] wbuf   [8];
  logic       oePrev = 1'b0;
  bit         done   = 1'b0;

  task automatic check(input string req, input int act, input int exp);
    nCmp++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Scoreboard monitor: each byte the master reads is compared in order.
  initial begin
    forever begin
      @(obsEv);
      if (expQ.size() == 0) check("SB-extra", obsByte, 256);
      else begin
        exp_t e;
        e = expQ.pop_front();
        check(e.req, obsByte, e.val);
      end
    end
  end

  // R9 watch: drive must not move while the bus clock is high.
  always @(posedge clk) begin
    if (rstN && sclDrv && (sdaOe != oePrev)) r9Viol++;
    oePrev <= sdaOe;
  end

  task automatic hold(); repeat (Q) @(negedge clk); endtask

  task automatic startCond();
    sdaDrv = 1'b1; hold(); sclDrv = 1'b1; hold();
    sdaDrv = 1'b0; hold(); sclDrv = 1'b0; hold();
  endtask

  task automatic stopCond();
    sdaDrv = 1'b0; hold(); sclDrv = 1'b1; hold(); sdaDrv = 1'b1; hold();
  endtask

  task automatic writeByte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sdaDrv = b[i]; hold(); sclDrv = 1'b1; hold(); hold(); sclDrv = 1'b0;
    end
    sdaDrv = 1'b1; hold(); sclDrv = 1'b1; hold();
    ack = ~sdaBus; hold(); sclDrv = 1'b0; hold();
  endtask

  task automatic readByte(input bit ackIt, output logic [7:0] d);
    sdaDrv = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      hold(); sclDrv = 1'b1; hold(); d[i] = sdaBus; hold(); sclDrv = 1'b0;
    end
    obsByte = d;
    -> obsEv;
    hold(); sdaDrv = ~ackIt; hold(); sclDrv = 1'b1; hold(); hold();
    sclDrv = 1'b0; hold(); sdaDrv = 1'b1;
  endtask

  task automatic pushExp(input string req);
    exp_t e;
    e.req = req; e.val = shadow[shCnt];
    expQ.push_back(e);
    shCnt = (shCnt + 1) % 128;
  endtask

  // Write n bytes of wbuf starting at addr; model wraps within 8-byte page.
  task automatic doWrite(input logic [7:0] addr, input int n, input string req);
    bit ack;
    int a;
    startCond();
    writeByte(CW, ack);   check({req, " ctrl ack R1"}, ack, 1);
    writeByte(addr, ack); check({req, " addr ack"}, ack, 1);
    for (int i = 0; i < n; i++) begin
      writeByte(wbuf[i], ack); check({req, " data ack R2"}, ack, 1);
    end
    stopCond();
    a = addr & 8'h7F;
    for (int i = 0; i < n; i++) begin
      shadow[a] = wbuf[i];
      a = (a & 8'h78) | ((a + 1) & 7);
    end
    shCnt = a;
  endtask

  task automatic doRandRead(input logic [7:0] addr, input int n, input string req);
    bit ack;
    logic [7:0] d;
    startCond();
    writeByte(CW, ack);   check({req, " ctrl ack R5"}, ack, 1);
    writeByte(addr, ack); check({req, " addr ack R5"}, ack, 1);
    startCond();
    writeByte(CR, ack);   check({req, " read ctrl ack R5"}, ack, 1);
    shCnt = addr & 8'h7F;
    for (int i = 0; i < n; i++) begin
      pushExp(req);
      readByte(i != n - 1, d);
    end
    stopCond();
  endtask

  task automatic doCurRead(input int n, input string req);
    bit ack;
    logic [7:0] d;
    startCond();
    writeByte(CR, ack); check({req, " cur ctrl ack"}, ack, 1);
    for (int i = 0; i < n; i++) begin
      pushExp(req);
      readByte(i != n - 1, d);
    end
    hold();
    check("R7 released after NACK", sdaOe, 0);
    stopCond();
  endtask

  initial begin
    bit ack;
    logic [7:0] d;
    for (int i = 0; i < 128; i++) shadow[i] = 8'h00;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    check("R9 reset drive", sdaOe, 0);

    doCurRead(1, "R4 after reset");

    wbuf[0] = 8'h5A; doWrite(8'h10, 1, "R2");
    doRandRead(8'h10, 1, "R5");

    wbuf[0] = 8'hA1; wbuf[1] = 8'hA2; wbuf[2] = 8'hA3; wbuf[3] = 8'hA4;
    doWrite(8'h1E, 4, "R3");
    doRandRead(8'h18, 8, "R3");

    wbuf[0] = 8'h77; doWrite(8'h20, 1, "R2");
    doRandRead(8'h1E, 2, "R6");
    doCurRead(2, "R4");

    wbuf[0] = 8'h3C; doWrite(8'h00, 1, "R2");
    wbuf[0] = 8'hC3; doWrite(8'h7F, 1, "R2");
    doRandRead(8'h7F, 3, "R6 rollover");

    // R1: wrong select bits, then wrong code; nothing acknowledged or stored.
    startCond();
    writeByte(8'hA2, ack);  check("R1 select mismatch nack", ack, 0);
    writeByte(8'h10, ack);  check("R1 ignored addr", ack, 0);
    writeByte(8'hFF, ack);  check("R1 ignored data", ack, 0);
    stopCond();
    startCond();
    writeByte(8'hBA, ack);  check("R1 code mismatch nack", ack, 0);
    stopCond();
    doRandRead(8'h10, 1, "R1 memory kept");

    // R8: data byte, then repeated start; buffered write must be dropped.
    startCond();
    writeByte(CW, ack);     check("R8 ctrl ack", ack, 1);
    writeByte(8'h41, ack);  check("R8 addr ack", ack, 1);
    writeByte(8'h99, ack);  check("R8 data ack", ack, 1);
    startCond();
    writeByte(CR, ack);     check("R8 read ctrl ack", ack, 1);
    shCnt = 8'h42;
    pushExp("R8 counter read");
    readByte(1'b0, d);
    stopCond();
    doRandRead(8'h41, 1, "R8 no commit");

    hold();
    check("R9 drive stable while SCL high", r9Viol, 0);
    check("SB all expected bytes seen", expQ.size(), 0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nCmp++; nBad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end

endmodule